// File: doc/BRIEF.md
# Single-Channel Bus-Master Byte Mover

This block copies a programmed number of bytes between system RAM and a single peripheral FIFO that sits at one fixed I/O address. It works on a bus with 8-bit data and 24-bit addresses. The processor sets up the job through a small register window: the transfer direction, a 24-bit RAM start address and a 16-bit byte count. Writing the start bit begins the job. The engine stops the processor with its ready line, asks it to float its buses, and then runs the bus itself, one read cycle and one write cycle per byte. Each byte waits for the peripheral's request.

When the count runs out, the engine gives the bus back in a fixed order. If an interrupt line goes active, it gives the bus back early in the same order and keeps its address and count. Software resumes the job by writing the start bit again. The engine is clocked by the system bus clock and adds no wait states.

Top module: `bytemove_dma`

## Requirements
- R1: After reset, mpu_rdy and mpu_be are 1, bus_own is 0, rd_n, wr_n and dack_n are 1, and every register reads 0.
- R2: Register offsets are as follows: 0 is control/status, 1, 2 and 3 are the address bytes from low to high, and 4 and 5 are the count bytes from low to high. Reads return the live address and count. On offset 0, a write uses bit0 as start and bit1 as direction (1 = RAM to FIFO, 0 = FIFO to RAM). A read of offset 0 returns bit0 busy, bit1 direction, bit2 suspended and bit3 done.
- R3: Takeover order after a start is fixed. In the first cycle mpu_rdy goes to 0 while mpu_be stays 1. In the next cycle mpu_be goes to 0. In the cycle after that bus_own goes to 1. mpu_be is never 0 while mpu_rdy is 1.
- R4: For each byte, the engine stays idle on the bus until dreq is 1. It then runs a read cycle (rd_n=0) at the source address, then a write cycle (wr_n=0) at the destination address, carrying the byte it read. The FIFO address is FIFO_ADDR (default 0x00D300).
- R5: dack_n is 0 only during the one strobe cycle that addresses the FIFO, and only while dreq is 1. There is exactly one such cycle per byte.
- R6: After every byte the RAM address goes up by one and the count goes down by one. The carry passes across byte boundaries.
- R7: The write cycle of the last byte is followed by three steps, one per cycle. First bus_own goes to 0 while mpu_be stays 0. Next mpu_be goes to 1 while mpu_rdy stays 0. Last mpu_rdy goes to 1. The status then reads done=1 and busy=0.
- R8: If irq_n or nmi_n is 0 while the engine waits for dreq or finishes a byte, it releases the bus in the R7 order and reports suspended. The address and count keep the progress made so far.
- R9: After a suspension, writing start again takes the bus in the R3 order and moves the remaining bytes.
- R10: A start written while the count is 0 sets done at once and leaves mpu_rdy at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low register window select |
| reg_we | input | 1 | Register write when selected |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_n | input | 1 | Active-low maskable interrupt line |
| nmi_n | input | 1 | Active-low non-maskable interrupt line |
| dreq | input | 1 | Peripheral request, high when FIFO can move a byte |
| dack_n | output | 1 | Active-low peripheral acknowledge |
| mpu_rdy | output | 1 | Processor ready, 0 halts it |
| mpu_be | output | 1 | Processor bus enable, 0 floats its buses |
| bus_own | output | 1 | Engine drives address, data and strobes |
| bus_addr | output | 24 | Bus address while owned |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Two events can land in the same cycle: the write of the last byte and an interrupt that arrives during that byte. The completion must win, so done is reported and suspended is not. A mid-transfer interrupt is raised once a set number of FIFO bytes has moved, and the bench counts the bytes that reached the destination. The suspended address and count must agree with that count, and resuming must finish the copy intact. The release order is also judged cycle by cycle, both at completion and at suspension.

// File: rtl/dmab_pkg.sv
`timescale 1ns/1ps
package dmab_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GRAB  = 3'd1,
        ST_TAKE  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_READ  = 3'd4,
        ST_WRITE = 3'd5,
        ST_DROP  = 3'd6,
        ST_FREE  = 3'd7
    } dmab_state_e;

    localparam int STAT_BUSY = 0;
    localparam int STAT_DIR  = 1;
    localparam int STAT_SUSP = 2;
    localparam int STAT_DONE = 3;
endpackage

// File: rtl/dmab_ptr.sv
`timescale 1ns/1ps
module dmab_ptr #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int DW     = 8,
    parameter int LANES  = ADDR_W / DW + CNT_W / DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    ld_lane,
    input  logic [DW-1:0]       wdata,
    input  logic                step,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic                cnt_zero,
    output logic                cnt_last,
    output logic [LANES*DW-1:0] lanes_flat
);
    localparam int AL = ADDR_W / DW;
    localparam int CL = CNT_W / DW;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        for (int i = 0; i < AL; i++) begin
            if (ld_lane[i]) ptr_d.addr[i*DW +: DW] = wdata;
        end
        for (int i = 0; i < CL; i++) begin
            if (ld_lane[AL+i]) ptr_d.cnt[i*DW +: DW] = wdata;
        end
        if (step) begin
            ptr_d.addr = ptr_q.addr + ADDR_W'(1);
            ptr_d.cnt  = ptr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ram_addr   = ptr_q.addr;
    assign cnt_zero   = (ptr_q.cnt == '0);
    assign cnt_last   = (ptr_q.cnt == CNT_W'(1));
    assign lanes_flat = {ptr_q.cnt, ptr_q.addr};
endmodule

// File: rtl/dmab_ctrl.sv
`timescale 1ns/1ps
module dmab_ctrl
    import dmab_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          DW        = 8,
    parameter logic [ADDR_W-1:0] FIFO_ADDR = 24'h00D300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              start_dir,
    input  logic              cnt_zero,
    input  logic              cnt_last,
    input  logic              int_pend,
    input  logic              dreq,
    input  logic [DW-1:0]     bus_rdata,
    input  logic [ADDR_W-1:0] ram_addr,
    output logic              busy,
    output logic              step,
    output logic [DW-1:0]     status,
    output logic              mpu_rdy,
    output logic              mpu_be,
    output logic              bus_own,
    output logic              rd_n,
    output logic              wr_n,
    output logic              dack_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DW-1:0]     bus_wdata
);
    typedef struct packed {
        dmab_state_e   st;
        logic          dir;
        logic          susp;
        logic          done;
        logic [DW-1:0] data;
    } ctl_t;

    ctl_t c_d, c_q;
    logic fifo_cyc;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_req) begin
                    c_d.dir  = start_dir;
                    c_d.susp = 1'b0;
                    c_d.done = cnt_zero;
                    if (!cnt_zero) c_d.st = ST_GRAB;
                end
            end
            ST_GRAB: c_d.st = ST_TAKE;
            ST_TAKE: c_d.st = ST_WAIT;
            ST_WAIT: begin
                if (int_pend) begin
                    c_d.susp = 1'b1;
                    c_d.st   = ST_DROP;
                end else if (dreq) begin
                    c_d.st = ST_READ;
                end
            end
            ST_READ: begin
                c_d.data = bus_rdata;
                c_d.st   = ST_WRITE;
            end
            ST_WRITE: begin
                if (cnt_last) begin
                    c_d.done = 1'b1;
                    c_d.st   = ST_DROP;
                end else if (int_pend) begin
                    c_d.susp = 1'b1;
                    c_d.st   = ST_DROP;
                end else begin
                    c_d.st = ST_WAIT;
                end
            end
            ST_DROP: c_d.st = ST_FREE;
            ST_FREE: c_d.st = ST_IDLE;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        busy     = (c_q.st != ST_IDLE);
        step     = (c_q.st == ST_WRITE);
        mpu_rdy  = (c_q.st == ST_IDLE);
        mpu_be   = (c_q.st == ST_IDLE) || (c_q.st == ST_GRAB) || (c_q.st == ST_FREE);
        bus_own  = (c_q.st == ST_WAIT) || (c_q.st == ST_READ) || (c_q.st == ST_WRITE);
        rd_n     = (c_q.st != ST_READ);
        wr_n     = (c_q.st != ST_WRITE);
        fifo_cyc = ((c_q.st == ST_READ) && !c_q.dir) || ((c_q.st == ST_WRITE) && c_q.dir);
        dack_n   = !(fifo_cyc && dreq);
        bus_addr = '0;
        if (bus_own) bus_addr = fifo_cyc ? FIFO_ADDR : ram_addr;
        bus_wdata = (c_q.st == ST_WRITE) ? c_q.data : '0;
        status = '0;
        status[STAT_BUSY] = busy;
        status[STAT_DIR]  = c_q.dir;
        status[STAT_SUSP] = c_q.susp;
        status[STAT_DONE] = c_q.done;
    end
endmodule

// File: rtl/dmab_rdmux.sv
`timescale 1ns/1ps
module dmab_rdmux #(
    parameter int DW     = 8,
    parameter int REG_AW = 3,
    parameter int LANES  = 5
) (
    input  logic [REG_AW-1:0]   sel,
    input  logic [DW-1:0]       status,
    input  logic [LANES*DW-1:0] lanes_flat,
    output logic [DW-1:0]       rdata
);
    always_comb begin
        rdata = '0;
        if (sel == '0) rdata = status;
        for (int i = 0; i < LANES; i++) begin
            if (sel == REG_AW'(i + 1)) rdata = lanes_flat[i*DW +: DW];
        end
    end
endmodule

// File: rtl/bytemove_dma.sv
`timescale 1ns/1ps
module bytemove_dma #(
    parameter int          ADDR_W    = 24,
    parameter int          CNT_W     = 16,
    parameter int          DATA_W    = 8,
    parameter int          REG_AW    = 3,
    parameter logic [23:0] FIFO_ADDR = 24'h00D300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              irq_n,
    input  logic              nmi_n,
    input  logic              dreq,
    output logic              dack_n,
    output logic              mpu_rdy,
    output logic              mpu_be,
    output logic              bus_own,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rd_n,
    output logic              wr_n
);
    localparam int LANES = ADDR_W / DATA_W + CNT_W / DATA_W;

    logic                    wr_hit, busy, step, start_req;
    logic                    cnt_zero, cnt_last, int_pend;
    logic [LANES-1:0]        ld_lane;
    logic [ADDR_W-1:0]       ram_addr;
    logic [LANES*DATA_W-1:0] lanes_flat;
    logic [DATA_W-1:0]       status;

    assign wr_hit    = !cs_n && reg_we;
    assign start_req = wr_hit && (reg_addr == '0) && reg_wdata[0] && !busy;
    assign int_pend  = !irq_n || !nmi_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ld_lane[g] = wr_hit && !busy && (reg_addr == REG_AW'(g + 1));
    end

    dmab_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DW(DATA_W), .LANES(LANES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ld_lane(ld_lane), .wdata(reg_wdata),
        .step(step), .ram_addr(ram_addr), .cnt_zero(cnt_zero),
        .cnt_last(cnt_last), .lanes_flat(lanes_flat)
    );

    dmab_ctrl #(.ADDR_W(ADDR_W), .DW(DATA_W), .FIFO_ADDR(ADDR_W'(FIFO_ADDR))) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_dir(reg_wdata[1]),
        .cnt_zero(cnt_zero), .cnt_last(cnt_last), .int_pend(int_pend),
        .dreq(dreq), .bus_rdata(bus_rdata), .ram_addr(ram_addr),
        .busy(busy), .step(step), .status(status),
        .mpu_rdy(mpu_rdy), .mpu_be(mpu_be), .bus_own(bus_own),
        .rd_n(rd_n), .wr_n(wr_n), .dack_n(dack_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata)
    );

    dmab_rdmux #(.DW(DATA_W), .REG_AW(REG_AW), .LANES(LANES)) u_rdmux (
        .sel(reg_addr), .status(status), .lanes_flat(lanes_flat), .rdata(reg_rdata)
    );
endmodule

// File: rtl/dmab_chk.sv
`timescale 1ns/1ps
module dmab_chk #(
    parameter int          ADDR_W    = 24,
    parameter logic [23:0] FIFO_ADDR = 24'h00D300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dreq,
    input logic              dack_n,
    input logic              mpu_rdy,
    input logic              mpu_be,
    input logic              bus_own,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_n,
    input logic              wr_n
);
    AST_BE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n) !mpu_be |-> !mpu_rdy); // R3
    AST_OWN_NEEDS_BE: assert property (@(posedge clk) disable iff (!rst_n) bus_own |-> !mpu_be); // R3
    AST_TAKE_ORDER: assert property (@(posedge clk) disable iff (!rst_n) $fell(mpu_be) |-> $past(!mpu_rdy)); // R3
    AST_RDY_LAST: assert property (@(posedge clk) disable iff (!rst_n) $rose(mpu_rdy) |-> $past(mpu_be)); // R7
    AST_OWN_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(mpu_be) |-> $past(!bus_own)); // R7
    AST_DACK_QUAL: assert property (@(posedge clk) disable iff (!rst_n) !dack_n |-> (dreq && (!rd_n || !wr_n))); // R5
    AST_DACK_FIFO: assert property (@(posedge clk) disable iff (!rst_n) !dack_n |-> (bus_addr == ADDR_W'(FIFO_ADDR))); // R5
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> $past(!rd_n)); // R4
    AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n || !wr_n) |-> bus_own); // R4
endmodule

bind bytemove_dma dmab_chk #(.ADDR_W(ADDR_W), .FIFO_ADDR(FIFO_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .dack_n(dack_n), .mpu_rdy(mpu_rdy),
    .mpu_be(mpu_be), .bus_own(bus_own), .bus_addr(bus_addr), .rd_n(rd_n), .wr_n(wr_n)
);

// File: tb/test_bytemove_dma.sv
`timescale 1ns/1ps
module test_bytemove_dma;
    localparam logic [23:0] FIFO_A = 24'h00D300;
    // vector: {dir, start address, count, dreq gap}
    localparam logic [36:0] VEC [3] = '{
        {1'b1, 24'h000010, 8'd5, 4'd0},
        {1'b0, 24'h020040, 8'd7, 4'd2},
        {1'b1, 24'h1234FE, 8'd4, 4'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata, bus_wdata, bus_rdata = '0;
    logic irq_n = 1'b1, nmi_n = 1'b1, dreq = 1'b1;
    logic dack_n, mpu_rdy, mpu_be, bus_own, rd_n, wr_n;
    logic [23:0] bus_addr;

    int checks = 0, errors = 0;
    logic [7:0] ram [256];
    logic [7:0] src [64];
    logic [7:0] sink [64];
    int src_n = 0, sink_n = 0, dst_n = 0, dack_cnt = 0, order_bad = 0;
    int gap = 0, gap_left = 0;
    bit served = 0;

    always #2.5 clk = ~clk;

    bytemove_dma i_bytemove_dma (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n), .nmi_n(nmi_n),
        .dreq(dreq), .dack_n(dack_n), .mpu_rdy(mpu_rdy), .mpu_be(mpu_be),
        .bus_own(bus_own), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory and peripheral model, evaluated mid-cycle
    task automatic model_step();
        if (rst_n && !mpu_be && mpu_rdy) order_bad++;
        if (bus_own && !wr_n) begin
            dst_n++;
            if (bus_addr == FIFO_A) begin sink[sink_n] = bus_wdata; sink_n++; end
            else ram[bus_addr[7:0]] = bus_wdata;
        end
        if (bus_own && !rd_n) begin
            if (bus_addr == FIFO_A) begin bus_rdata = src[src_n]; src_n++; end
            else bus_rdata = ram[bus_addr[7:0]];
        end
        if (!dack_n) begin
            dack_cnt++;
            served = 1;
        end else if (served) begin
            served = 0;
            if (gap > 0) begin dreq = 1'b0; gap_left = gap; end
        end else if (gap_left > 0) begin
            gap_left--;
            if (gap_left == 0) dreq = 1'b1;
        end
    endtask

    initial forever begin
        @(negedge clk);
        model_step();
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        cs_n = 1'b1; reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        cs_n = 1'b0; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        cs_n = 1'b1;
    endtask

    task automatic rd_addr(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        rd_reg(3'd1, b0); rd_reg(3'd2, b1); rd_reg(3'd3, b2);
        v = {b2, b1, b0};
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] b0, b1;
        rd_reg(3'd4, b0); rd_reg(3'd5, b1);
        v = {b1, b0};
    endtask

    task automatic prog(input logic [23:0] a, input logic [15:0] c);
        wr_reg(3'd1, a[7:0]); wr_reg(3'd2, a[15:8]); wr_reg(3'd3, a[23:16]);
        wr_reg(3'd4, c[7:0]); wr_reg(3'd5, c[15:8]);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            rd_reg(3'd0, s);
            if (!s[0]) break;
        end
    endtask

    task automatic fill(input int salt);
        for (int j = 0; j < 256; j++) ram[j] = 8'(j) ^ 8'h5A;
        for (int k = 0; k < 64; k++) src[k] = 8'hA0 + 8'(k) + 8'(salt);
        src_n = 0; sink_n = 0; dst_n = 0; dack_cnt = 0;
        served = 0; gap_left = 0; dreq = 1'b1;
    endtask

    initial begin
        #750000;
        errors++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s;
        logic [23:0] av;
        logic [15:0] cv;
        int rdy_low, mism;
        fill(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "rdy/be/own", {mpu_rdy, mpu_be, bus_own}, 3'b110);
        check("R1", "rd/wr/dack", {rd_n, wr_n, dack_n}, 3'b111);
        rd_reg(3'd0, s); check("R1", "status", s, 8'h00);
        rd_addr(av); check("R1", "address", av, 24'h0);
        rd_cnt(cv); check("R1", "count", cv, 16'h0);

        // R2 register readback
        prog(24'h332211, 16'h5544);
        rd_addr(av); check("R2", "address readback", av, 24'h332211);
        rd_cnt(cv); check("R2", "count readback", cv, 16'h5544);

        // R10 zero count start
        prog(24'h000000, 16'h0000);
        wr_reg(3'd0, 8'h01);
        rdy_low = 0;
        for (int k = 0; k < 4; k++) begin #1 if (!mpu_rdy) rdy_low++; @(negedge clk); end
        check("R10", "rdy low cycles", rdy_low, 0);
        rd_reg(3'd0, s); check("R10", "status done", s, 8'h08);

        // R3 takeover and R7 release, cycle by cycle
        fill(9); gap = 0;
        prog(24'h000080, 16'd2);
        wr_reg(3'd0, 8'h03);
        #1 check("R3", "cycle1 rdy/be/own", {mpu_rdy, mpu_be, bus_own}, 3'b010);
        @(negedge clk); #1 check("R3", "cycle2 rdy/be/own", {mpu_rdy, mpu_be, bus_own}, 3'b000);
        @(negedge clk); #1 check("R3", "cycle3 rdy/be/own", {mpu_rdy, mpu_be, bus_own}, 3'b001);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk); #1;
            if (!bus_own) break;
        end
        check("R7", "release1 rdy/be/own", {mpu_rdy, mpu_be, bus_own}, 3'b000);
        @(negedge clk); #1 check("R7", "release2 rdy/be/own", {mpu_rdy, mpu_be, bus_own}, 3'b010);
        @(negedge clk); #1 check("R7", "release3 rdy/be/own", {mpu_rdy, mpu_be, bus_own}, 3'b110);
        rd_reg(3'd0, s); check("R7", "status done", s, 8'h0A);

        // table of transfers: R4 R5 R6 R7
        for (int v = 0; v < 3; v++) begin
            logic        vdir;
            logic [23:0] va;
            logic [7:0]  vc;
            logic [3:0]  vg;
            {vdir, va, vc, vg} = VEC[v];
            fill(v); gap = int'(vg);
            prog(va, {8'h00, vc});
            wr_reg(3'd0, {6'b0, vdir, 1'b1});
            wait_idle();
            mism = 0;
            for (int i = 0; i < int'(vc); i++) begin
                logic [7:0] ix;
                ix = va[7:0] + 8'(i);
                if (vdir) begin if (sink[i] !== (ix ^ 8'h5A)) mism++; end
                else      begin if (ram[ix] !== src[i]) mism++; end
            end
            check("R4", "bytes mismatched", mism, 0);
            check("R5", "acknowledged FIFO cycles", dack_cnt, int'(vc));
            rd_addr(av); check("R6", "final address", av, va + 24'(vc));
            rd_cnt(cv);  check("R6", "final count", cv, 16'h0);
            rd_reg(3'd0, s); check("R7", "final status", s, {4'b0, 1'b1, 1'b0, vdir, 1'b0});
        end
        check("R3", "be low while rdy high", order_bad, 0);

        // R8 / R9 irq suspension and resume, inbound
        fill(5); gap = 1;
        prog(24'h000020, 16'd10);
        wr_reg(3'd0, 8'h01);
        for (int k = 0; k < 500; k++) begin @(negedge clk); if (src_n >= 3) break; end
        irq_n = 1'b0;
        wait_idle();
        rd_reg(3'd0, s); check("R8", "status suspended", s, 8'h04);
        check("R8", "some bytes left", (dst_n >= 3 && dst_n < 10), 1);
        rd_addr(av); check("R8", "address kept", av, 24'h20 + 24'(dst_n));
        rd_cnt(cv);  check("R8", "count kept", cv, 16'(10 - dst_n));
        repeat (4) @(negedge clk);
        check("R8", "bus idle while suspended", {mpu_rdy, mpu_be, bus_own}, 3'b110);
        irq_n = 1'b1;
        wr_reg(3'd0, 8'h01);
        #1 check("R9", "resume takeover", {mpu_rdy, mpu_be}, 2'b01);
        wait_idle();
        mism = 0;
        for (int i = 0; i < 10; i++) if (ram[8'h20 + 8'(i)] !== src[i]) mism++;
        check("R9", "resumed bytes mismatched", mism, 0);
        rd_cnt(cv); check("R9", "count after resume", cv, 16'h0);
        rd_reg(3'd0, s); check("R9", "status after resume", s, 8'h08);

        // R8 nmi suspension, outbound
        fill(7); gap = 2;
        prog(24'h000090, 16'd6);
        wr_reg(3'd0, 8'h03);
        for (int k = 0; k < 500; k++) begin @(negedge clk); if (sink_n >= 2) break; end
        nmi_n = 1'b0;
        wait_idle();
        rd_reg(3'd0, s); check("R8", "nmi status suspended", s, 8'h06);
        rd_cnt(cv); check("R8", "nmi count kept", cv, 16'(6 - sink_n));
        nmi_n = 1'b1;
        wr_reg(3'd0, 8'h03);
        wait_idle();
        mism = 0;
        for (int i = 0; i < 6; i++) if (sink[i] !== ((8'h90 + 8'(i)) ^ 8'h5A)) mism++;
        check("R9", "nmi resumed bytes mismatched", mism, 0);
        check("R3", "be low while rdy high at end", order_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule